// File: doc/BRIEF.md
# Programmable YCbCr/RGB Color Converter

A pipelined converter that takes pixels of three 8-bit components on a valid/ready stream and produces one pixel per cycle with a fixed three-cycle latency. It has two conversion modes and a bypass. In the YCbCr-to-RGB modes, a signed offset is added to each input component, and the results pass through a programmable 3x3 matrix. In the RGB-to-YCbCr modes, the matrix is applied to the raw components, and a signed offset is added to each output. Bypass forwards pixels unchanged, whatever the mode field holds.

Software sets up the converter through a small write-only register port. One control word holds the mode and the bypass bit. Six data words each hold two fields: the nine matrix coefficients and the three offsets. Writes go into a shadow copy. A frame-start strobe copies the shadow copy into the working set, so no frame ever mixes two configurations. Software picks coefficients for a given colour standard or range. The block applies whatever it is given.

Top module: `pix_csc`

## Requirements
- R1: After reset, out_valid is low and in_ready is high. Control and shadow start with bypass set, mode 0 and all fields zero, so pixels pass through unchanged.
- R2: A pixel accepted in cycle k appears on the output in cycle k+3 when out_ready stays high. With no stall, one pixel is accepted every cycle.
- R3: While out_valid is high and out_ready is low, the output pixel holds and out_valid stays high. in_ready is high whenever out_valid is low. No pixel is lost, duplicated or reordered.
- R4: Address 0 is control: bit 0 is bypass and bits 2:1 are the mode. Addresses 1 to 6 each hold a low field in bits 10:0 and a high field in bits 26:16 (9-bit fields use bits 8:0 and 24:16), in the pairs K00/K01, K02/K10, K11/K12, K20/K21, K22/OF0, OF1/OF2. Other bits and address 7 are ignored.
- R5: Register writes change nothing until a frame_start strobe copies the shadow settings into the working set. Pixels sent before the strobe use the old settings.
- R6: Mode 1 (YCbCr to RGB): out_r = sum over j of K[r][j] * (in_j + OF_j).
- R7: Mode 3 (RGB to YCbCr): out_r = sum over j of K[r][j] * in_j, and then OF_r is added to the result.
- R8: Coefficients K are 11-bit two's complement with 8 fractional bits, so 0x100 is 1.0 and 0x79c is about -0.39. Offsets OF are 9-bit two's complement integers, so 0x180 is -128.
- R9: The full-precision sum, with any output offset scaled by 256, has 128 added. It is then shifted right arithmetically by 8 and clamped to the range 0..255.
- R10: Mode 0 gives the same results as mode 1, and mode 2 gives the same results as mode 3.
- R11: When bypass is set, pixels pass through unchanged, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Strobe that commits the shadow settings |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_c0 | input | 8 | Input component 0 (Y or R) |
| in_c1 | input | 8 | Input component 1 (Cb or G) |
| in_c2 | input | 8 | Input component 2 (Cr or B) |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_c0 | output | 8 | Output component 0 (R or Y) |
| out_c1 | output | 8 | Output component 1 (G or Cb) |
| out_c2 | output | 8 | Output component 2 (B or Cr) |

## Verification
The bench builds the block with its default parameters: 8-bit components, 11-bit coefficients with 8 fractional bits, and 9-bit offsets. At this size, exact integer arithmetic in the bench can predict every output.

- **RGB to YCbCr:** the bench sweeps the RGB cube at sixteen steps per axis, with random output stalls.
- **YCbCr to RGB:** it sweeps luma across its full span against a grid of chroma values. This pushes the results past both clamp limits.
- **Other modes:** shorter sweeps cover the alias modes, the bypass override and the deferred commit.

// File: rtl/pix_csc_pkg.sv
package pix_csc_pkg;

   typedef enum logic [1:0] {
      CSC_YUV_TO_RGB = 2'd0,
      CSC_YCC_TO_RGB = 2'd1,
      CSC_RGB_TO_YUV = 2'd2,
      CSC_RGB_TO_YCC = 2'd3
   } csc_mode_e;

   localparam int unsigned N_CMP   = 3;
   localparam int unsigned N_COEF  = N_CMP * N_CMP;
   localparam int unsigned N_OFS   = N_CMP;
   localparam int unsigned N_WORDS = 1 + (N_COEF + N_OFS) / 2;
   localparam int unsigned HI_LSB  = 16;

   // Offsets move to the output side for the two RGB-source modes.
   function automatic logic offset_after_matrix(csc_mode_e m);
      return m[1];
   endfunction

endpackage

// File: rtl/pix_csc_cfg.sv
module pix_csc_cfg
   import pix_csc_pkg::*;
#(
   parameter int COEF_W = 11,
   parameter int OFS_W  = 9,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      cfg_we,
   input  logic [ADDR_W-1:0]         cfg_addr,
   input  logic [DATA_W-1:0]         cfg_wdata,
   input  logic                      frame_start,
   output logic                      act_bypass,
   output csc_mode_e                 act_mode,
   output logic [N_COEF*COEF_W-1:0]  act_coef,
   output logic [N_OFS*OFS_W-1:0]    act_ofs
);

   localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

   if (COEF_W > int'(HI_LSB)) begin : g_bad_coef_w
      $error("pix_csc_cfg: COEF_W must fit in a half word");
   end
   if (DATA_W < int'(HI_LSB) + COEF_W) begin : g_bad_data_w
      $error("pix_csc_cfg: DATA_W too small for two fields");
   end
   if ((2 ** ADDR_W) < int'(N_WORDS)) begin : g_bad_addr_w
      $error("pix_csc_cfg: ADDR_W cannot reach every word");
   end

   logic       sh_bypass, ac_bypass;
   logic [1:0] sh_mode,   ac_mode;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_bypass <= 1'b1;
         ac_bypass <= 1'b1;
         sh_mode   <= '0;
         ac_mode   <= '0;
      end else begin
         if (cfg_we && cfg_addr == CTRL_ADDR) begin
            sh_bypass <= cfg_wdata[0];
            sh_mode   <= cfg_wdata[2:1];
         end
         if (frame_start) begin
            ac_bypass <= sh_bypass;
            ac_mode   <= sh_mode;
         end
      end
   end

   assign act_bypass = ac_bypass;
   assign act_mode   = csc_mode_e'(ac_mode);

   // Field k lives in word 1 + k/2, low half when k is even.
   for (genvar k = 0; k < int'(N_COEF); k++) begin : g_coef
      localparam logic [ADDR_W-1:0] WA = ADDR_W'(1 + k / 2);
      localparam int LSB = (k % 2) * int'(HI_LSB);
      logic [COEF_W-1:0] sh_q, ac_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            sh_q <= '0;
            ac_q <= '0;
         end else begin
            if (cfg_we && cfg_addr == WA) sh_q <= cfg_wdata[LSB +: COEF_W];
            if (frame_start)              ac_q <= sh_q;
         end
      end
      assign act_coef[k*COEF_W +: COEF_W] = ac_q;
   end

   for (genvar k = 0; k < int'(N_OFS); k++) begin : g_ofs
      localparam int KF = k + int'(N_COEF);
      localparam logic [ADDR_W-1:0] WA = ADDR_W'(1 + KF / 2);
      localparam int LSB = (KF % 2) * int'(HI_LSB);
      logic [OFS_W-1:0] sh_q, ac_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            sh_q <= '0;
            ac_q <= '0;
         end else begin
            if (cfg_we && cfg_addr == WA) sh_q <= cfg_wdata[LSB +: OFS_W];
            if (frame_start)              ac_q <= sh_q;
         end
      end
      assign act_ofs[k*OFS_W +: OFS_W] = ac_q;
   end

   logic unused_wdata;
   assign unused_wdata = ^cfg_wdata;

endmodule

// File: rtl/pix_csc_row.sv
module pix_csc_row #(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 11,
   parameter int OFS_W  = 9,
   parameter int FRAC_W = 8,
   parameter int N_TERM = 3,
   localparam int OP_W  = PIX_W + 2
) (
   input  logic                     clk,
   input  logic                     en,
   input  logic [N_TERM*OP_W-1:0]   opnd,
   input  logic [N_TERM*COEF_W-1:0] coef,
   input  logic [OFS_W-1:0]         post_ofs,
   input  logic                     post_en,
   input  logic                     bypass,
   input  logic [PIX_W-1:0]         raw,
   output logic [PIX_W-1:0]         result
);

   localparam int PROD_W = OP_W + COEF_W;
   localparam int ACC_W  = PROD_W + $clog2(N_TERM) + 1;
   localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(2 ** (FRAC_W - 1));
   localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'(2 ** PIX_W - 1);

   if (OFS_W + FRAC_W >= ACC_W) begin : g_bad_acc
      $error("pix_csc_row: accumulator too narrow for the scaled offset");
   end

   // Stage 2: full-precision dot product.
   logic signed [ACC_W-1:0] dot, dot_q;

   always_comb begin
      dot = '0;
      for (int j = 0; j < N_TERM; j++) begin
         dot = dot + ACC_W'(signed'(opnd[j*OP_W +: OP_W]))
                   * ACC_W'(signed'(coef[j*COEF_W +: COEF_W]));
      end
   end

   always_ff @(posedge clk) begin
      if (en) dot_q <= dot;
   end

   // Stage 3: output offset, rounding, clamp, bypass select.
   logic signed [ACC_W-1:0] ofs_term, acc, shifted;
   logic [PIX_W-1:0]        clamped;

   always_comb begin
      ofs_term = post_en ? (ACC_W'(signed'(post_ofs)) <<< FRAC_W) : '0;
      acc      = dot_q + ofs_term + HALF;
      shifted  = acc >>> FRAC_W;
      if (shifted[ACC_W-1])        clamped = '0;
      else if (shifted > PIX_MAX)  clamped = '1;
      else                         clamped = shifted[PIX_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (en) result <= bypass ? raw : clamped;
   end

endmodule

// File: rtl/pix_csc.sv
module pix_csc
   import pix_csc_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 11,
   parameter int OFS_W  = 9,
   parameter int FRAC_W = 8,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              frame_start,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [PIX_W-1:0]  in_c0,
   input  logic [PIX_W-1:0]  in_c1,
   input  logic [PIX_W-1:0]  in_c2,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [PIX_W-1:0]  out_c0,
   output logic [PIX_W-1:0]  out_c1,
   output logic [PIX_W-1:0]  out_c2
);

   localparam int OP_W = PIX_W + 2;

   if (OFS_W > PIX_W + 1) begin : g_bad_ofs_w
      $error("pix_csc: OFS_W must not exceed PIX_W + 1");
   end
   if (FRAC_W < 1 || FRAC_W >= COEF_W) begin : g_bad_frac_w
      $error("pix_csc: FRAC_W must lie in 1 .. COEF_W-1");
   end

   // Working configuration.
   logic                      cfg_bypass;
   csc_mode_e                 cfg_mode;
   logic [N_COEF*COEF_W-1:0]  cfg_coef;
   logic [N_OFS*OFS_W-1:0]    cfg_ofs;
   logic [2:0]                cfg_ctrl_view;

   pix_csc_cfg #(
      .COEF_W (COEF_W),
      .OFS_W  (OFS_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_cfg (
      .clk         (clk),
      .rst         (rst),
      .cfg_we      (cfg_we),
      .cfg_addr    (cfg_addr),
      .cfg_wdata   (cfg_wdata),
      .frame_start (frame_start),
      .act_bypass  (cfg_bypass),
      .act_mode    (cfg_mode),
      .act_coef    (cfg_coef),
      .act_ofs     (cfg_ofs)
   );

   assign cfg_ctrl_view = {cfg_mode, cfg_bypass};

   // Pipeline control: the whole pipe advances together.
   logic pipe_en, v1, v2;
   logic post_mode;

   assign pipe_en   = !out_valid || out_ready;
   assign in_ready  = pipe_en;
   assign post_mode = offset_after_matrix(cfg_mode);

   always_ff @(posedge clk) begin
      if (rst) begin
         v1        <= 1'b0;
         v2        <= 1'b0;
         out_valid <= 1'b0;
      end else if (pipe_en) begin
         v1        <= in_valid;
         v2        <= v1;
         out_valid <= v2;
      end
   end

   // Stage 1: optional input offset, raw copy kept for bypass.
   logic [N_CMP-1:0][PIX_W-1:0] in_px, s1_raw, s2_raw, out_px;
   logic [N_CMP-1:0][OP_W-1:0]  s1_opnd_d, s1_opnd;

   assign in_px = {in_c2, in_c1, in_c0};

   for (genvar i = 0; i < int'(N_CMP); i++) begin : g_pre
      logic [OP_W-1:0] ofs_ext;
      assign ofs_ext = {{(OP_W-OFS_W){cfg_ofs[i*OFS_W + OFS_W - 1]}},
                        cfg_ofs[i*OFS_W +: OFS_W]};
      assign s1_opnd_d[i] = {2'b00, in_px[i]} + (post_mode ? '0 : ofs_ext);
   end

   always_ff @(posedge clk) begin
      if (pipe_en) begin
         s1_opnd <= s1_opnd_d;
         s1_raw  <= in_px;
         s2_raw  <= s1_raw;
      end
   end

   // Stages 2 and 3: one row engine per output component.
   for (genvar r = 0; r < int'(N_CMP); r++) begin : g_row
      pix_csc_row #(
         .PIX_W  (PIX_W),
         .COEF_W (COEF_W),
         .OFS_W  (OFS_W),
         .FRAC_W (FRAC_W),
         .N_TERM (N_CMP)
      ) u_row (
         .clk      (clk),
         .en       (pipe_en),
         .opnd     (s1_opnd),
         .coef     (cfg_coef[r*N_CMP*COEF_W +: N_CMP*COEF_W]),
         .post_ofs (cfg_ofs[r*OFS_W +: OFS_W]),
         .post_en  (post_mode),
         .bypass   (cfg_bypass),
         .raw      (s2_raw[r]),
         .result   (out_px[r])
      );
   end

   assign out_c0 = out_px[0];
   assign out_c1 = out_px[1];
   assign out_c2 = out_px[2];

endmodule

// File: rtl/pix_csc_chk.sv
module pix_csc_chk #(
   parameter int PIX_W = 8
) (
   input logic               clk,
   input logic               rst,
   input logic               in_valid,
   input logic               in_ready,
   input logic               out_valid,
   input logic               out_ready,
   input logic               frame_start,
   input logic [3*PIX_W-1:0] out_px,
   input logic [2:0]         ctrl_view
);

   // R1: pipeline is empty and accepting right after reset.
   a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!out_valid && in_ready));

   // R2: three-cycle latency when the output is not stalled.
   a_r2_latency: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) ##1 out_ready ##1 out_ready |=> out_valid);

   // R3: a stalled output holds its pixel.
   a_r3_stall_hold: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_px)));

   // R3: an empty output stage never blocks the input.
   a_r3_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready);

   // R5: working control changes only on a frame strobe.
   a_r5_commit_on_strobe: assert property (@(posedge clk) disable iff (rst)
      !frame_start |=> $stable(ctrl_view));

endmodule

bind pix_csc pix_csc_chk #(.PIX_W(PIX_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .frame_start (frame_start),
   .out_px      ({out_c2, out_c1, out_c0}),
   .ctrl_view   (cfg_ctrl_view)
);

// File: tb/tb_pix_csc.sv
module tb_pix_csc;

   localparam int PERIOD = 4;
   localparam int QN     = 8192;

   logic        clk = 1'b0;
   logic        rst;
   logic        cfg_we;
   logic [2:0]  cfg_addr;
   logic [31:0] cfg_wdata;
   logic        frame_start;
   logic        in_valid, in_ready;
   logic [7:0]  in_c0, in_c1, in_c2;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [7:0]  out_c0, out_c1, out_c2;

   pix_csc dut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .frame_start(frame_start),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
   );

   always #(PERIOD/2) clk = ~clk;

   int    n_chk = 0, n_err = 0;
   string tag;
   int    exp_q [QN];
   int    wr_i = 0, rd_i = 0;
   bit    bp_en = 0;
   bit    hold_pend = 0;
   int    held;
   bit    done = 0;

   // Bench model of the register state (R4 field positions).
   int s_ctrl, m_ctrl;
   int s_fld [12];
   int m_fld [12];

   // K00..K22, OF0..OF2 as raw field bits.
   int ycc_set [12] = '{'h12a, 'h000, 'h199, 'h12a, 'h79c, 'h730,
                        'h12a, 'h204, 'h000, 'h1f0, 'h180, 'h180};
   int rgb_set [12] = '{'h041, 'h081, 'h019, 'h7db, 'h7b6, 'h070,
                        'h070, 'h7a2, 'h7ee, 'h010, 'h080, 'h080};

   task automatic check(bit ok, string req, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%06h expected=%06h", req, act, expv);
      end
   endtask

   function automatic int sx(int v, int w);
      return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
   endfunction

   // R6, R7, R8, R9, R10, R11 arithmetic.
   function automatic int model(int c0, int c1, int c2);
      int inp [3];
      int res [3];
      int s, v;
      bit post;
      inp[0] = c0; inp[1] = c1; inp[2] = c2;
      if ((m_ctrl & 1) != 0) return (c2 << 16) | (c1 << 8) | c0;
      post = ((m_ctrl >> 2) & 1) != 0;
      for (int r = 0; r < 3; r++) begin
         s = 0;
         for (int j = 0; j < 3; j++)
            s += sx(m_fld[3*r+j], 11) * (inp[j] + (post ? 0 : sx(m_fld[9+j], 9)));
         if (post) s += sx(m_fld[9+r], 9) * 256;
         s += 128;
         v = s >>> 8;
         res[r] = (v < 0) ? 0 : (v > 255) ? 255 : v;
      end
      return (res[2] << 16) | (res[1] << 8) | res[0];
   endfunction

   task automatic cfg_write(int a, logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a[2:0]; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
      if (a == 0) s_ctrl = int'(d[2:0]);
      else if (a <= 6) begin
         int k;
         k = 2 * (a - 1);
         s_fld[k]   = (k   >= 9) ? int'(d[8:0])   : int'(d[10:0]);
         s_fld[k+1] = (k+1 >= 9) ? int'(d[24:16]) : int'(d[26:16]);
      end
   endtask

   task automatic load_set(input int f [12]);
      for (int w = 1; w <= 6; w++)
         cfg_write(w, (32'(f[2*w-1]) << 16) | 32'(f[2*w-2]) | 32'hF800_F800);
   endtask

   task automatic strobe();
      frame_start = 1'b1;
      @(posedge clk); #1;
      frame_start = 1'b0;
      m_ctrl = s_ctrl;
      for (int i = 0; i < 12; i++) m_fld[i] = s_fld[i];
   endtask

   task automatic send(int c0, int c1, int c2);
      exp_q[wr_i % QN] = model(c0, c1, c2);
      wr_i++;
      in_valid = 1'b1;
      in_c0 = 8'(c0); in_c1 = 8'(c1); in_c2 = 8'(c2);
      forever begin
         @(negedge clk);
         if (in_ready) break;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (rd_i != wr_i) @(negedge clk);
      @(posedge clk); #1;
   endtask

   task automatic ycc_sweep(int ystep);
      int cg [5] = '{0, 60, 128, 200, 255};
      for (int y = 0; y < 256; y += ystep)
         for (int a = 0; a < 5; a++)
            for (int b = 0; b < 5; b++)
               send(y, cg[a], cg[b]);
   endtask

   task automatic rgb_sweep(int st);
      for (int r = 0; r < 256; r += st)
         for (int g = 0; g < 256; g += st)
            for (int b = 0; b < 256; b += st)
               send(r, g, b);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   // Output ready pattern: random stalls when enabled.
   always @(posedge clk) begin
      #1;
      out_ready = bp_en ? ($urandom_range(0, 3) != 0) : 1'b1;
   end

   // Output monitor and scoreboard (R3 plus the phase tag).
   always @(negedge clk) begin
      int pk;
      pk = int'({8'h00, out_c2, out_c1, out_c0});
      if (!rst) begin
         if (hold_pend) check(out_valid && pk == held, "R3 stall hold", pk, held);
         hold_pend = out_valid && !out_ready;
         held = pk;
         if (out_valid && out_ready) begin
            if (rd_i == wr_i) check(1'b0, {tag, " unexpected pixel"}, pk, 0);
            else begin
               check(pk == exp_q[rd_i % QN], tag, pk, exp_q[rd_i % QN]);
               rd_i++;
            end
         end
      end
   end

   initial begin
      #(200000 * PERIOD);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", rd_i, wr_i);
      finish_run();
   end

   initial begin
      longint t0;
      int lat;
      rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      frame_start = 1'b0; in_valid = 1'b0;
      in_c0 = '0; in_c1 = '0; in_c2 = '0;
      s_ctrl = 1; m_ctrl = 1;
      for (int i = 0; i < 12; i++) begin s_fld[i] = 0; m_fld[i] = 0; end
      tag = "R1";
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
      check(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
      @(posedge clk); #1;
      rst = 1'b0;

      // R1, R11: reset state forwards pixels unchanged.
      tag = "R1 R11 passthrough after reset";
      for (int i = 0; i < 16; i++) send(i * 17, 255 - i * 13, i * 7);
      drain();

      // R2: latency and full throughput.
      tag = "R2 latency data";
      send(1, 2, 3);
      lat = 0;
      do begin @(negedge clk); lat++; end while (!out_valid && lat < 8);
      check(lat == 3, "R2 latency cycles", lat, 3);
      @(posedge clk); #1;
      drain();
      t0 = $time;
      for (int i = 0; i < 16; i++) send(i, i + 1, i + 2);
      check(($time - t0) / PERIOD == 16, "R2 throughput cycles",
            int'(($time - t0) / PERIOD), 16);
      drain();

      // R4, R5: writes stay in the shadow until the strobe.
      load_set(ycc_set);
      cfg_write(0, 32'hFFFF_FFF2);
      tag = "R5 deferred commit";
      for (int i = 0; i < 12; i++) send(i * 20, 128, 255 - i * 20);
      drain();
      strobe();

      // R6, R8, R9: YCbCr to RGB, with clamps at both ends.
      tag = "R6 R8 R9 ycc to rgb";
      ycc_sweep(5);
      tag = "R9 clamp";
      send(255, 255, 255); send(0, 0, 0); send(16, 128, 128); send(235, 128, 128);
      drain();

      // R10: mode 0 matches mode 1.
      cfg_write(0, 32'h0);
      strobe();
      tag = "R10 mode0 as mode1";
      ycc_sweep(17);
      drain();

      // R11: bypass wins over a conversion mode.
      cfg_write(0, 32'h3);
      strobe();
      tag = "R11 bypass override";
      ycc_sweep(51);
      drain();

      // R7, R3: RGB to YCbCr under random output stalls.
      load_set(rgb_set);
      cfg_write(0, 32'h6);
      strobe();
      bp_en = 1;
      tag = "R7 R3 rgb to ycc stalled";
      rgb_sweep(17);
      drain();
      bp_en = 0;

      // R10: mode 2 matches mode 3.
      cfg_write(0, 32'h4);
      strobe();
      tag = "R10 mode2 as mode3";
      rgb_sweep(51);
      drain();

      // R4: address 7 is ignored.
      cfg_write(7, 32'hFFFF_FFFF);
      strobe();
      tag = "R4 unused address";
      rgb_sweep(85);
      drain();

      finish_run();
   end

endmodule